// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block sits on a register bus and gives firmware read access to a set of configuration items. Software first writes a 16-bit key that names an item, then reads the item's bytes out through a data register, 1 to 8 bytes per access. The port remembers which item is current and how far into it the reader has got, so consecutive reads walk through the item. Keys that name no item, reads past the end of an item, and items of zero length all read back as zero without moving the read position.

Two banks of items share one index space; the top bit of the key picks the bank. Item contents are loaded from the host side through a simple fill port that writes single bytes and per-item lengths. Bank 0, index 0 is a fixed 4-byte signature item that the fill port cannot change, and it is the item selected after reset.

The port has two bus layouts, picked by the `combined_mode` strap. In split layout the control (selector) register and the data register are separate. In combined layout both share one narrow port, and the access size decides which register is meant. Writes to the data register are accepted but change nothing.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the current item is bank 0 index 0 at byte position 0, and that item always holds 4 bytes 0x43, 0x46, 0x47, 0x50 in that order; the response outputs are all zero.
- R2: An accepted selector write takes key bits [13:0] as the item index and key bit 15 as the bank; key bit 14 is ignored, and the byte position is set to 0 on every selector write, valid key or not.
- R3: A key whose index is 48 or more (16 fixed plus 32 file entries) leaves no item selected; data reads then return zero and do not move the position, until a valid key is written.
- R4: A data read of N bytes returns item bytes in string order with the first byte in bits [8N-1:8N-8], the bits at and above bit 8N are zero, and the position advances by N.
- R5: When fewer than N bytes remain, the missing low-order byte positions are zero, the position stops at the item length, and later reads return zero.
- R6: An item of length 0 reads back as zero and the position stays 0.
- R7: With the same index, key bit 15 = 0 and = 1 reach two independent items.
- R8: In split layout (combined_mode = 0) acc_reg = 0 is the control register, which accepts only a 2-byte write at byte offset 0; acc_reg = 1 is the data register, which accepts reads and writes of size 1 to 8 at offset 0 only; accepted data writes change neither the position nor the item.
- R9: In combined layout (combined_mode = 1) acc_reg and acc_off are ignored, a 1-byte read is a data read, a 1-byte write is ignored, a 2-byte write is a selector write, and every other access is rejected.
- R10: A rejected access returns rsp_err = 1 with rsp_data = 0 and leaves the current item and position unchanged.
- R11: The fill port writes byte fill_byte at fill_pos of item (fill_bank, fill_idx) when fill_en is high and sets the item length to min(fill_len, 16) when fill_len_en is high; fills aimed at bank 0 index 0 or at an index of 48 or more are ignored.
- R12: Every access with acc_en high gives rsp_valid = 1 in the following cycle with that access's rsp_data and rsp_err (rsp_data is zero for writes), and rsp_valid is 0 in a cycle after no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| combined_mode | input | 1 | Strap: 1 selects the single narrow-port layout |
| acc_en | input | 1 | Bus access strobe, one cycle per access |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_reg | input | 1 | Split layout: 0 control register, 1 data register |
| acc_off | input | 3 | Byte offset of the access inside the register |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 16 | Selector key for selector writes |
| fill_en | input | 1 | Write one item byte |
| fill_len_en | input | 1 | Write one item length |
| fill_bank | input | 1 | Bank of the item being filled |
| fill_idx | input | 6 | Index of the item being filled |
| fill_pos | input | 4 | Byte position inside the item |
| fill_byte | input | 8 | Byte value to store |
| fill_len | input | 5 | Item length in bytes |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_data | output | 64 | Read data, right-aligned to the access size |
| rsp_err | output | 1 | The previous access was rejected |

## Verification
Reads are issued with sizes 1, 2, 3, 4 and 8 against items of 3, 10 and 16 bytes, so exact fits, partial runs at the end of an item and reads entirely past the end are told apart by their zero padding and by where the next read resumes. Keys are varied in the bank bit, the ignored bit 14 and the index just below and at the entry limit, and empty items and repeated selection in mid-item separate position reset from item change. Every access form rejected by each layout is followed by a read whose value shows that neither the item nor the position moved, and fills aimed at the signature item are followed by reads that still return the tag.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  // Key layout: the bank bit and the index field are decoded by the port.
  localparam int KEY_W        = 16;
  localparam int KEY_BANK_BIT = 15;
  localparam int KEY_IDX_BITS = 14;

  // What one bus access does to the port.
  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_SELECT = 3'd1,
    ACT_READ   = 3'd2,
    ACT_IGNORE = 3'd3,
    ACT_REJECT = 3'd4
  } act_e;

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
#(
  parameter int RD_BYTES = 8,
  parameter int SIZE_W   = 4
) (
  input  logic              combined_mode,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_reg,
  input  logic [2:0]        acc_off,
  input  logic [SIZE_W-1:0] acc_size,
  output act_e              act
);

  localparam logic [SIZE_W-1:0] SZ_ONE = SIZE_W'(1);
  localparam logic [SIZE_W-1:0] SZ_TWO = SIZE_W'(2);
  localparam logic [SIZE_W-1:0] SZ_MAX = SIZE_W'(RD_BYTES);

  logic size_ok;
  assign size_ok = (acc_size >= SZ_ONE) && (acc_size <= SZ_MAX);

  always_comb begin
    act = ACT_NONE;
    if (acc_en) begin
      if (combined_mode) begin
        if (acc_size == SZ_ONE)              act = acc_wr ? ACT_IGNORE : ACT_READ;
        else if (acc_size == SZ_TWO && acc_wr) act = ACT_SELECT;
        else                                  act = ACT_REJECT;
      end else if (!acc_reg) begin
        if (acc_wr && acc_size == SZ_TWO && acc_off == 3'd0) act = ACT_SELECT;
        else                                                  act = ACT_REJECT;
      end else begin
        if (acc_off == 3'd0 && size_ok) act = acc_wr ? ACT_IGNORE : ACT_READ;
        else                            act = ACT_REJECT;
      end
    end
  end

endmodule

// File: rtl/cfgport_store.sv
module cfgport_store #(
  parameter int          N_BANK   = 2,
  parameter int          N_ENT    = 48,
  parameter int          MAX_LEN  = 16,
  parameter int          RD_BYTES = 8,
  parameter int          OFF_W    = 32,
  parameter logic [31:0] SIG_TAG  = 32'h4346_4750,
  localparam int         BANK_W   = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  localparam int         IDX_W    = $clog2(N_ENT),
  localparam int         POS_W    = $clog2(MAX_LEN),
  localparam int         LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fill_en,
  input  logic                         fill_len_en,
  input  logic [BANK_W-1:0]            fill_bank,
  input  logic [IDX_W-1:0]             fill_idx,
  input  logic [POS_W-1:0]             fill_pos,
  input  logic [7:0]                   fill_byte,
  input  logic [LEN_W-1:0]             fill_len,
  input  logic [BANK_W-1:0]            rd_bank,
  input  logic [IDX_W-1:0]             rd_idx,
  input  logic [OFF_W-1:0]             rd_off,
  output logic [LEN_W-1:0]             rd_len,
  output logic [RD_BYTES-1:0][7:0]     rd_lane
);

  localparam int               SIG_LEN   = 4;
  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

  logic [7:0]       mem_q [N_BANK][N_ENT][MAX_LEN];
  logic [LEN_W-1:0] len_q [N_BANK][N_ENT];

  // The signature item is not part of the writable store.
  logic fill_target_ok;
  logic rd_is_sig;
  logic [LEN_W-1:0] len_clamped;

  assign fill_target_ok = (32'(fill_idx) < N_ENT) &&
                          !((fill_bank == '0) && (fill_idx == '0));
  assign rd_is_sig      = (rd_bank == '0) && (rd_idx == '0);
  assign len_clamped    = (fill_len > LEN_LIMIT) ? LEN_LIMIT : fill_len;

  // Data bytes: no reset, written under an explicit enable.
  always_ff @(posedge clk) begin
    if (fill_en && fill_target_ok) begin
      mem_q[fill_bank][fill_idx][fill_pos] <= fill_byte;
    end
  end

  // Lengths reset to zero so every loadable item starts out empty.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < N_BANK; b++) begin
        for (int e = 0; e < N_ENT; e++) begin
          len_q[b][e] <= '0;
        end
      end
    end else if (fill_len_en && fill_target_ok) begin
      len_q[fill_bank][fill_idx] <= len_clamped;
    end
  end

  assign rd_len = rd_is_sig ? LEN_W'(SIG_LEN) : len_q[rd_bank][rd_idx];

  function automatic logic [7:0] sig_byte(input logic [1:0] pos);
    case (pos)
      2'd0:    sig_byte = SIG_TAG[31:24];
      2'd1:    sig_byte = SIG_TAG[23:16];
      2'd2:    sig_byte = SIG_TAG[15:8];
      default: sig_byte = SIG_TAG[7:0];
    endcase
  endfunction

  // One read lane per byte of the widest access.
  for (genvar g = 0; g < RD_BYTES; g++) begin : g_lane
    logic [OFF_W-1:0] addr;
    assign addr = rd_off + OFF_W'(g);
    always_comb begin
      rd_lane[g] = 8'h00;
      if (rd_is_sig) begin
        if (addr < OFF_W'(SIG_LEN)) rd_lane[g] = sig_byte(addr[1:0]);
      end else if (addr < OFF_W'(MAX_LEN)) begin
        rd_lane[g] = mem_q[rd_bank][rd_idx][addr[POS_W-1:0]];
      end
    end
  end

endmodule

// File: rtl/cfgport_cursor.sv
module cfgport_cursor
  import cfgport_pkg::*;
#(
  parameter int  N_ENT  = 48,
  parameter int  OFF_W  = 32,
  parameter int  SIZE_W = 4,
  localparam int IDX_W  = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_en,
  input  logic [KEY_W-1:0]  sel_key,
  input  logic              adv_en,
  input  logic [SIZE_W-1:0] adv_cnt,
  output logic              cur_valid,
  output logic              cur_bank,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [OFF_W-1:0]  cur_off
);

  logic [KEY_IDX_BITS-1:0] key_idx;
  logic                    key_ok;
  logic                    unused_key_rsvd;

  assign key_idx         = sel_key[KEY_IDX_BITS-1:0];
  assign key_ok          = 32'(key_idx) < N_ENT;
  assign unused_key_rsvd = sel_key[KEY_IDX_BITS];

  logic             valid_d, bank_d;
  logic [IDX_W-1:0] idx_d;
  logic [OFF_W-1:0] off_d;
  logic             cur_en;

  assign cur_en = sel_en || adv_en;

  always_comb begin
    valid_d = cur_valid;
    bank_d  = cur_bank;
    idx_d   = cur_idx;
    off_d   = cur_off;
    if (sel_en) begin
      valid_d = key_ok;
      bank_d  = key_ok ? sel_key[KEY_BANK_BIT] : 1'b0;
      idx_d   = key_ok ? key_idx[IDX_W-1:0] : '0;
      off_d   = '0;
    end else if (adv_en) begin
      off_d   = cur_off + OFF_W'(adv_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid <= 1'b1;
      cur_bank  <= 1'b0;
      cur_idx   <= '0;
      cur_off   <= '0;
    end else if (cur_en) begin
      cur_valid <= valid_d;
      cur_bank  <= bank_d;
      cur_idx   <= idx_d;
      cur_off   <= off_d;
    end
  end

endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
  import cfgport_pkg::*;
#(
  parameter int          N_FIXED  = 16,
  parameter int          N_FILES  = 32,
  parameter int          MAX_LEN  = 16,
  parameter int          RD_BYTES = 8,
  parameter int          OFF_W    = 32,
  parameter logic [31:0] SIG_TAG  = 32'h4346_4750,
  localparam int         N_ENT    = N_FIXED + N_FILES,
  localparam int         IDX_W    = $clog2(N_ENT),
  localparam int         POS_W    = $clog2(MAX_LEN),
  localparam int         LEN_W    = $clog2(MAX_LEN + 1),
  localparam int         SIZE_W   = $clog2(RD_BYTES + 1),
  localparam int         RD_W     = 8 * RD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              combined_mode,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_reg,
  input  logic [2:0]        acc_off,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [KEY_W-1:0]  acc_wdata,
  input  logic              fill_en,
  input  logic              fill_len_en,
  input  logic              fill_bank,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [POS_W-1:0]  fill_pos,
  input  logic [7:0]        fill_byte,
  input  logic [LEN_W-1:0]  fill_len,
  output logic              rsp_valid,
  output logic [RD_W-1:0]   rsp_data,
  output logic              rsp_err
);

  act_e                      act;
  logic                      cur_valid;
  logic                      cur_bank;
  logic [IDX_W-1:0]          cur_idx;
  logic [OFF_W-1:0]          cur_off;
  logic [LEN_W-1:0]          item_len;
  logic [RD_BYTES-1:0][7:0]  lane;
  logic [RD_BYTES-1:0]       lane_ok;
  logic [RD_W-1:0]           rd_word;
  logic [SIZE_W-1:0]         rd_cnt;

  cfgport_decode #(
    .RD_BYTES (RD_BYTES),
    .SIZE_W   (SIZE_W)
  ) i_decode (
    .combined_mode (combined_mode),
    .acc_en        (acc_en),
    .acc_wr        (acc_wr),
    .acc_reg       (acc_reg),
    .acc_off       (acc_off),
    .acc_size      (acc_size),
    .act           (act)
  );

  cfgport_cursor #(
    .N_ENT  (N_ENT),
    .OFF_W  (OFF_W),
    .SIZE_W (SIZE_W)
  ) i_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_en    (act == ACT_SELECT),
    .sel_key   (acc_wdata),
    .adv_en    (act == ACT_READ),
    .adv_cnt   (rd_cnt),
    .cur_valid (cur_valid),
    .cur_bank  (cur_bank),
    .cur_idx   (cur_idx),
    .cur_off   (cur_off)
  );

  cfgport_store #(
    .N_BANK   (2),
    .N_ENT    (N_ENT),
    .MAX_LEN  (MAX_LEN),
    .RD_BYTES (RD_BYTES),
    .OFF_W    (OFF_W),
    .SIG_TAG  (SIG_TAG)
  ) i_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_en     (fill_en),
    .fill_len_en (fill_len_en),
    .fill_bank   (fill_bank),
    .fill_idx    (fill_idx),
    .fill_pos    (fill_pos),
    .fill_byte   (fill_byte),
    .fill_len    (fill_len),
    .rd_bank     (cur_bank),
    .rd_idx      (cur_idx),
    .rd_off      (cur_off),
    .rd_len      (item_len),
    .rd_lane     (lane)
  );

  // A lane delivers a byte when it is inside the access and inside the item.
  always_comb begin
    for (int i = 0; i < RD_BYTES; i++) begin
      lane_ok[i] = cur_valid && (SIZE_W'(i) < acc_size) &&
                   ((cur_off + OFF_W'(i)) < OFF_W'(item_len));
    end
  end

  // Bytes shift in from the right: first byte ends up most significant,
  // and lanes past the end of the item contribute zero padding.
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < RD_BYTES; i++) begin
      if (SIZE_W'(i) < acc_size) begin
        rd_word = {rd_word[RD_W-9:0], (lane_ok[i] ? lane[i] : 8'h00)};
      end
    end
  end

  assign rd_cnt = SIZE_W'($countones(lane_ok));

  // Response registers.
  logic            rsp_valid_d, rsp_err_d;
  logic [RD_W-1:0] rsp_data_d;

  always_comb begin
    rsp_valid_d = acc_en;
    rsp_err_d   = (act == ACT_REJECT);
    rsp_data_d  = (act == ACT_READ) ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      if (acc_en || rsp_valid) begin
        rsp_err  <= rsp_err_d;
        rsp_data <= rsp_data_d;
      end
    end
  end

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
  import cfgport_pkg::*;
#(
  parameter int OFF_W  = 32,
  parameter int IDX_W  = 6,
  parameter int SIZE_W = 4,
  parameter int RD_W   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic [SIZE_W-1:0] acc_size,
  input act_e              act,
  input logic              cur_valid,
  input logic              cur_bank,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [OFF_W-1:0]  cur_off,
  input logic              rsp_valid,
  input logic [RD_W-1:0]   rsp_data,
  input logic              rsp_err
);

  // R2: any selector write restarts the item at byte 0
  p_sel_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_SELECT) |=> (cur_off == '0));

  // R3: no item selected -> zero data and a frozen position
  p_invalid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_READ && !cur_valid) |=> (rsp_data == '0 && $stable(cur_off)));

  // R4: bytes above the access size are zero
  p_pad_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_READ && 32'(acc_size) < RD_W / 8)
      |=> ((rsp_data >> (8 * $past(acc_size))) == '0));

  // R8: an ignored data write touches nothing
  p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_IGNORE) |=> (!rsp_err && rsp_data == '0 && $stable(cur_off)));

  // R10: a rejected access flags an error and keeps the cursor
  p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_REJECT) |=> (rsp_err && rsp_data == '0 && $stable(cur_off) &&
                             $stable(cur_idx) && $stable(cur_bank) &&
                             $stable(cur_valid)));

  // R12: one response per access, in the next cycle
  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> rsp_valid);

  p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !rsp_valid);

endmodule

bind cfg_item_port cfgport_chk #(
  .OFF_W  (OFF_W),
  .IDX_W  (IDX_W),
  .SIZE_W (SIZE_W),
  .RD_W   (RD_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_size  (acc_size),
  .act       (act),
  .cur_valid (cur_valid),
  .cur_bank  (cur_bank),
  .cur_idx   (cur_idx),
  .cur_off   (cur_off),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_err   (rsp_err)
);

// File: tb/test_cfg_item_port.sv
`timescale 1ns/1ps
module test_cfg_item_port;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        combined_mode;
  logic        acc_en, acc_wr, acc_reg;
  logic [2:0]  acc_off;
  logic [3:0]  acc_size;
  logic [15:0] acc_wdata;
  logic        fill_en, fill_len_en, fill_bank;
  logic [5:0]  fill_idx;
  logic [3:0]  fill_pos;
  logic [7:0]  fill_byte;
  logic [4:0]  fill_len;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        rsp_err;

  always #5 clk = ~clk;

  cfg_item_port i_cfg_item_port (
    .clk (clk), .rst_n (rst_n), .combined_mode (combined_mode),
    .acc_en (acc_en), .acc_wr (acc_wr), .acc_reg (acc_reg),
    .acc_off (acc_off), .acc_size (acc_size), .acc_wdata (acc_wdata),
    .fill_en (fill_en), .fill_len_en (fill_len_en), .fill_bank (fill_bank),
    .fill_idx (fill_idx), .fill_pos (fill_pos), .fill_byte (fill_byte),
    .fill_len (fill_len), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
    .rsp_err (rsp_err)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  string cur_tag  = "R1";
  bit    model_on = 0;

  // ---------------- behavioural reference model ----------------
  localparam int ENTRIES = 48;
  byte unsigned m_mem [2][ENTRIES][16];
  int           m_len [2][ENTRIES];
  bit           m_valid;
  int           m_bank, m_idx, m_off;
  bit           exp_v, exp_e;
  logic [63:0]  exp_d;
  byte unsigned tag_bytes [4] = '{8'h43, 8'h46, 8'h47, 8'h50};

  function automatic int item_len(int b, int e);
    if (b == 0 && e == 0) return 4;
    return m_len[b][e];
  endfunction

  function automatic byte unsigned item_byte(int b, int e, int p);
    if (b == 0 && e == 0) return tag_bytes[p];
    return m_mem[b][e][p];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 1; m_bank = 0; m_idx = 0; m_off = 0;
      foreach (m_len[b, e]) m_len[b][e] = 0;
      exp_v = 0; exp_e = 0; exp_d = '0;
      model_on = 1;
    end else begin
      exp_v = acc_en; exp_e = 0; exp_d = '0;
      if (acc_en) begin
        int kind; // 0 reject, 1 select, 2 read, 3 ignore
        kind = 0;
        if (combined_mode) begin
          if (acc_size == 1) kind = acc_wr ? 3 : 2;
          else if (acc_size == 2 && acc_wr) kind = 1;
        end else if (acc_reg == 1'b0) begin
          if (acc_wr && acc_size == 2 && acc_off == 0) kind = 1;
        end else if (acc_off == 0 && acc_size >= 1 && acc_size <= 8) begin
          kind = acc_wr ? 3 : 2;
        end
        case (kind)
          0: exp_e = 1;
          1: begin
            int ix;
            ix = int'(acc_wdata & 16'h3FFF);
            m_off = 0;
            if (ix < ENTRIES) begin
              m_valid = 1; m_bank = int'(acc_wdata[15]); m_idx = ix;
            end else begin
              m_valid = 0;
            end
          end
          2: begin
            if (m_valid && m_off < item_len(m_bank, m_idx)) begin
              int n;
              n = int'(acc_size);
              while (n > 0 && m_off < item_len(m_bank, m_idx)) begin
                exp_d = (exp_d << 8) | 64'(item_byte(m_bank, m_idx, m_off));
                m_off++; n--;
              end
              exp_d = exp_d << (8 * n);
            end
          end
          default: ;
        endcase
      end
      if (!(fill_bank == 1'b0 && fill_idx == 0) && fill_idx < ENTRIES) begin
        if (fill_en) m_mem[fill_bank][fill_idx][fill_pos] = fill_byte;
        if (fill_len_en) m_len[fill_bank][fill_idx] = (fill_len > 16) ? 16 : int'(fill_len);
      end
    end
  end

  // Compare the design against the model on every clock.
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      n_checks++;
      if (rsp_valid !== exp_v) begin
        n_fail++;
        $display("FAIL %s/R12 rsp_valid actual=%0b expected=%0b", cur_tag, rsp_valid, exp_v);
      end
      if (exp_v) begin
        n_checks++;
        if (rsp_data !== exp_d || rsp_err !== exp_e) begin
          n_fail++;
          $display("FAIL %s data/err actual=%h/%0b expected=%h/%0b",
                   cur_tag, rsp_data, rsp_err, exp_d, exp_e);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic access(input bit wr, input bit rg, input int off, input int sz,
                        input logic [15:0] wd, input bit chk,
                        input logic [63:0] want, input bit want_err);
    @(negedge clk);
    acc_en = 1; acc_wr = wr; acc_reg = rg; acc_off = 3'(off);
    acc_size = 4'(sz); acc_wdata = wd;
    @(negedge clk);
    acc_en = 0;
    if (chk) begin
      n_checks++;
      if (rsp_data !== want || rsp_err !== want_err) begin
        n_fail++;
        $display("FAIL %s actual=%h err=%0b expected=%h err=%0b",
                 cur_tag, rsp_data, rsp_err, want, want_err);
      end
    end
  endtask

  task automatic sel(input logic [15:0] key);
    access(1, 0, 0, 2, key, 0, '0, 0);
  endtask

  task automatic rd(input int sz, input logic [63:0] want);
    access(0, 1, 0, sz, '0, 1, want, 0);
  endtask

  task automatic rej(input bit wr, input bit rg, input int off, input int sz);
    access(wr, rg, off, sz, 16'h0010, 1, '0, 1);
  endtask

  task automatic fill_item(input bit b, input int ix, input int n,
                           input byte unsigned base, input int len);
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      fill_en = 1; fill_bank = b; fill_idx = 6'(ix);
      fill_pos = 4'(p); fill_byte = base + 8'(p);
    end
    @(negedge clk);
    fill_en = 0; fill_len_en = 1; fill_bank = b; fill_idx = 6'(ix);
    fill_len = 5'(len);
    @(negedge clk);
    fill_len_en = 0;
  endtask

  initial begin
    rst_n = 0; combined_mode = 0;
    acc_en = 0; acc_wr = 0; acc_reg = 0; acc_off = 0; acc_size = 0; acc_wdata = 0;
    fill_en = 0; fill_len_en = 0; fill_bank = 0; fill_idx = 0; fill_pos = 0;
    fill_byte = 0; fill_len = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R1";
    n_checks++;
    if (rsp_valid !== 1'b0 || rsp_data !== '0 || rsp_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs actual=%0b/%h/%0b expected=0/0/0",
               rsp_valid, rsp_data, rsp_err);
    end
    rd(4, 64'h4346_4750);
    cur_tag = "R5";
    sel(16'h0000);
    rd(8, 64'h4346_4750_0000_0000);
    rd(1, 64'h0);

    cur_tag = "R11";
    fill_item(0, 16, 10, 8'h10, 10);
    fill_item(1, 16, 3, 8'hA0, 3);
    fill_item(0, 47, 16, 8'h30, 16);
    fill_item(0, 20, 0, 8'h00, 0);
    fill_item(0, 17, 16, 8'h60, 20);

    cur_tag = "R4";
    sel(16'h0010);
    rd(2, 64'h1011);
    rd(3, 64'h12_1314);
    rd(1, 64'h15);
    cur_tag = "R5";
    rd(8, 64'h1617_1819_0000_0000);
    rd(4, 64'h0);

    cur_tag = "R7";
    sel(16'h8010);
    rd(4, 64'hA0A1_A200);
    cur_tag = "R2";
    sel(16'h4010);
    rd(1, 64'h10);

    cur_tag = "R3";
    sel(16'h0030);
    rd(8, 64'h0);
    sel(16'h3FFF);
    rd(2, 64'h0);
    sel(16'h002F);
    rd(8, 64'h3031_3233_3435_3637);
    rd(8, 64'h3839_3A3B_3C3D_3E3F);
    rd(8, 64'h0);

    cur_tag = "R6";
    sel(16'h0014);
    rd(4, 64'h0);
    rd(1, 64'h0);

    cur_tag = "R2";
    sel(16'h0010);
    rd(2, 64'h1011);
    sel(16'h0010);
    rd(1, 64'h10);

    cur_tag = "R8";
    access(1, 1, 0, 1, 16'hFFFF, 1, '0, 0);
    access(1, 1, 0, 8, 16'hFFFF, 1, '0, 0);
    rd(1, 64'h11);

    cur_tag = "R10";
    rej(0, 0, 0, 2);
    rej(1, 0, 0, 1);
    rej(1, 0, 2, 2);
    rej(0, 1, 1, 1);
    rej(0, 1, 0, 0);
    rej(0, 1, 0, 9);
    rd(1, 64'h12);

    cur_tag = "R11";
    fill_item(0, 0, 1, 8'hFF, 1);
    sel(16'h0000);
    rd(4, 64'h4346_4750);
    sel(16'h0011);
    rd(8, 64'h6061_6263_6465_6667);
    rd(8, 64'h6869_6A6B_6C6D_6E6F);
    rd(1, 64'h0);

    cur_tag = "R9";
    combined_mode = 1;
    access(1, 1, 5, 2, 16'h0010, 1, '0, 0);
    access(0, 0, 3, 1, '0, 1, 64'h10, 0);
    access(0, 1, 0, 1, '0, 1, 64'h11, 0);
    rej(0, 1, 0, 2);
    access(1, 0, 0, 1, 16'h00AA, 1, '0, 0);
    access(0, 0, 0, 1, '0, 1, 64'h12, 0);
    rej(1, 0, 0, 4);
    rej(0, 1, 0, 8);
    access(0, 1, 0, 1, '0, 1, 64'h13, 0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule